// File: doc/BRIEF.md
# Rate-Matching Video Line Buffer

This block sits between a standard-definition pixel source and a slower scaler that run on separate clocks. The source pushes pixels one per accepted cycle, and every `LINE_PIX` pixels make one line in a circular store of `LINES` line slots. The scaler reads pixels of its current line by pixel index and retires a line when it has finished with it. With the source ahead by about twelve lines at the end of a frame, a sixteen-slot store takes up the lead with room to spare.

The scaler does not wait for a full line. A one-cycle lock pulse on the write side marks the moment the `LOCK_PIX`-th pixel of the first line of a frame has been stored. The scaler aligns its output timing to that pulse, so latency stays at a fraction of a line and underrun is still avoided. The write-domain pixel position and the read-domain line index cross between the clocks in Gray code. The write side reports how many lines it is ahead of the reader, and each side keeps a sticky fault flag: overflow for writes and underrun for reads.

The write side runs a three-state machine. W_IDLE is the state after reset: it ignores pixels and moves to W_FILL on a frame start. W_FILL stores the first line and moves to W_RUN on the write that fires the lock. W_RUN stores pixels until the next frame start. A frame start taken in any state leads to W_FILL. `LINE_PIX` and `LINES` must be powers of two, and `LOCK_PIX` must not exceed `LINE_PIX`.

Top module: `vid_rate_linebuf`

## Requirements
- R1: After reset, w_lock, w_overflow, w_lead, r_valid and r_underrun are all 0.
- R2: Pixels offered before the first w_sof (state W_IDLE) are ignored: w_lead stays 0 and no lock pulse is produced.
- R3: w_sof resets the write position to line 0, pixel 0, clears w_overflow and arms the lock for the new frame.
- R4: w_lock is high for exactly one wclk cycle. It goes high at the edge that stores the LOCK_PIX-th pixel of the frame (pixel index LOCK_PIX-1 of line 0) and does not go high again before the next w_sof.
- R5: Every LINE_PIX accepted pixels complete one line. w_lead (LW+1 bits) equals the number of completed write lines minus the number of lines the reader has retired, as seen in the write domain.
- R6: A request (r_req, r_pix) for a pixel that has already been written returns that pixel of the current read line on r_data, with r_valid high, one rclk cycle later.
- R7: A request for a pixel at or beyond the synchronised write position drops r_valid and sets the sticky r_underrun. Only r_sof or reset clears it.
- R8: r_line_done moves the reader to the next line only if the current read line is complete. Otherwise it is ignored.
- R9: When w_lead equals LINES, an offered pixel is dropped and sets the sticky w_overflow. The pixel already stored in that slot is kept.
- R10: Once the lock has fired, pixels 0 to LOCK_PIX-1 of line 0 can be read while that line is still incomplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer clock |
| wrst_n | input | 1 | Producer-side active-low reset |
| w_sof | input | 1 | Frame start, resets the write side |
| w_valid | input | 1 | Pixel offered this cycle |
| w_data | input | PIX_BITS | Pixel value |
| w_lock | output | 1 | One-cycle lock pulse |
| w_overflow | output | 1 | Sticky overflow flag |
| w_lead | output | LW+1 | Lines the writer is ahead of the reader |
| rclk | input | 1 | Consumer clock |
| rrst_n | input | 1 | Consumer-side active-low reset |
| r_sof | input | 1 | Frame start, resets the read side |
| r_req | input | 1 | Pixel read request |
| r_pix | input | PW | Pixel index in the current read line |
| r_line_done | input | 1 | Retire the current read line |
| r_valid | output | 1 | r_data holds a valid pixel |
| r_data | output | PIX_BITS | Pixel read |
| r_underrun | output | 1 | Sticky underrun flag |

## Verification
A write position that is wrong by even one step changes when w_lock fires, so the lock index gives it away at once, within the first LOCK_PIX pixels of a frame. If line accounting or the Gray crossing goes wrong, w_lead reads wrong a few cycles after a line completes or a line is retired. If the availability compare goes wrong, r_valid or r_underrun comes out wrong on the very next rclk edge after a request at the written boundary. If the full check fails, the first pixel after the store fills corrupts line 0, and the next read of that line returns the wrong value.

// File: rtl/lb_pkg.sv
package lb_pkg;
    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_FILL = 2'd1,
        W_RUN  = 2'd2
    } wstate_e;
endpackage

// File: rtl/lb_gray_sync.sv
module lb_gray_sync #(
    parameter int W = 4
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_bin,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_bin
);
    logic [W-1:0] src_gray;
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) src_gray <= '0;
        else            src_gray <= src_bin ^ (src_bin >> 1);
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= src_gray;
            stab_q <= meta_q;
        end
    end

    // Gray to binary: bit i is the parity of all gray bits from i upward
    always_comb begin
        for (int i = 0; i < W; i++) begin
            dst_bin[i] = ^(stab_q >> i);
        end
    end
endmodule

// File: rtl/lb_write_ctrl.sv
module lb_write_ctrl
    import lb_pkg::*;
#(
    parameter int LW       = 4,
    parameter int PW       = 8,
    parameter int LOCK_PIX = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             valid,
    input  logic [LW:0]      rline_s,
    output logic             wen,
    output logic [LW+PW-1:0] waddr,
    output logic [LW+PW:0]   wpos,
    output logic [LW:0]      lead,
    output logic             lock,
    output logic             overflow
);
    localparam int WP = LW + PW + 1;
    localparam logic [WP-1:0] LOCK_POS = WP'(LOCK_PIX - 1);
    localparam logic [LW:0]   FULL     = {1'b1, {LW{1'b0}}};

    wstate_e       st, st_nx;
    logic [WP-1:0] pos;
    logic          full;
    logic          offer;

    assign lead  = pos[WP-1:PW] - rline_s;
    assign full  = (lead == FULL);
    assign offer = valid && !sof && (st != W_IDLE);
    assign wen   = offer && !full;
    assign waddr = pos[WP-2:0];
    assign wpos  = pos;

    always_comb begin
        st_nx = st;
        unique case (st)
            W_IDLE: if (sof) st_nx = W_FILL;
            W_FILL: begin
                if (sof)                          st_nx = W_FILL;
                else if (wen && pos == LOCK_POS)  st_nx = W_RUN;
            end
            W_RUN:  if (sof) st_nx = W_FILL;
            default: st_nx = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= W_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos      <= '0;
            lock     <= 1'b0;
            overflow <= 1'b0;
        end else if (sof) begin
            pos      <= '0;
            lock     <= 1'b0;
            overflow <= 1'b0;
        end else begin
            lock <= (st == W_FILL) && wen && (pos == LOCK_POS);
            if (wen)          pos      <= pos + 1'b1;
            if (offer && full) overflow <= 1'b1;
        end
    end

    AST_LOCK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) lock |=> !lock); // R4
    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n) !sof |=> (pos == $past(pos) || pos == $past(pos) + 1'b1)); // R5
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (valid && !sof && full) |=> $stable(pos)); // R9
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (st == W_IDLE) |-> (pos == '0 && !lock)); // R2
endmodule

// File: rtl/lb_read_ctrl.sv
module lb_read_ctrl #(
    parameter int LW = 4,
    parameter int PW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             req,
    input  logic [PW-1:0]    pix,
    input  logic             line_done,
    input  logic [LW+PW:0]   wpos_s,
    output logic [LW+PW-1:0] raddr,
    output logic [LW:0]      rline,
    output logic             rvalid,
    output logic             underrun
);
    localparam int WP = LW + PW + 1;
    localparam logic [WP-1:0] CAP = {1'b1, {(WP-1){1'b0}}};

    logic [WP-1:0] reqpos;
    logic [WP-1:0] avail;
    logic          ok;
    logic          line_full;

    assign reqpos    = {rline, pix};
    assign avail     = wpos_s - reqpos;
    assign ok        = (avail != '0) && (avail <= CAP);
    assign line_full = (wpos_s[WP-1:PW] != rline);
    assign raddr     = reqpos[WP-2:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rline    <= '0;
            rvalid   <= 1'b0;
            underrun <= 1'b0;
        end else if (sof) begin
            rline    <= '0;
            rvalid   <= 1'b0;
            underrun <= 1'b0;
        end else begin
            rvalid <= req && ok;
            if (req && !ok)            underrun <= 1'b1;
            if (line_done && line_full) rline    <= rline + 1'b1;
        end
    end

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (underrun && !sof) |=> underrun); // R7
    AST_RLINE_STEP: assert property (@(posedge clk) disable iff (!rst_n) !sof |=> (rline == $past(rline) || rline == $past(rline) + 1'b1)); // R8
    AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) rvalid |-> $past(req)); // R6
endmodule

// File: rtl/vid_rate_linebuf.sv
module vid_rate_linebuf #(
    parameter int PIX_BITS = 8,
    parameter int LINE_PIX = 256,
    parameter int LINES    = 16,
    parameter int LOCK_PIX = 128,
    localparam int PW      = $clog2(LINE_PIX),
    localparam int LW      = $clog2(LINES)
) (
    input  logic                wclk,
    input  logic                wrst_n,
    input  logic                w_sof,
    input  logic                w_valid,
    input  logic [PIX_BITS-1:0] w_data,
    output logic                w_lock,
    output logic                w_overflow,
    output logic [LW:0]         w_lead,
    input  logic                rclk,
    input  logic                rrst_n,
    input  logic                r_sof,
    input  logic                r_req,
    input  logic [PW-1:0]       r_pix,
    input  logic                r_line_done,
    output logic                r_valid,
    output logic [PIX_BITS-1:0] r_data,
    output logic                r_underrun
);
    localparam int WP    = LW + PW + 1;
    localparam int DEPTH = LINES * LINE_PIX;

    logic                wen;
    logic [WP-2:0]       waddr;
    logic [WP-1:0]       wpos;
    logic [WP-1:0]       wpos_s;
    logic [WP-2:0]       raddr;
    logic [LW:0]         rline;
    logic [LW:0]         rline_s;
    logic [PIX_BITS-1:0] mem [DEPTH];

    lb_write_ctrl #(.LW(LW), .PW(PW), .LOCK_PIX(LOCK_PIX)) u_wr (
        .clk(wclk), .rst_n(wrst_n), .sof(w_sof), .valid(w_valid),
        .rline_s(rline_s), .wen(wen), .waddr(waddr), .wpos(wpos),
        .lead(w_lead), .lock(w_lock), .overflow(w_overflow)
    );

    lb_read_ctrl #(.LW(LW), .PW(PW)) u_rd (
        .clk(rclk), .rst_n(rrst_n), .sof(r_sof), .req(r_req), .pix(r_pix),
        .line_done(r_line_done), .wpos_s(wpos_s), .raddr(raddr),
        .rline(rline), .rvalid(r_valid), .underrun(r_underrun)
    );

    lb_gray_sync #(.W(WP)) u_pos_x (
        .src_clk(wclk), .src_rst_n(wrst_n), .src_bin(wpos),
        .dst_clk(rclk), .dst_rst_n(rrst_n), .dst_bin(wpos_s)
    );

    lb_gray_sync #(.W(LW + 1)) u_line_x (
        .src_clk(rclk), .src_rst_n(rrst_n), .src_bin(rline),
        .dst_clk(wclk), .dst_rst_n(wrst_n), .dst_bin(rline_s)
    );

    always_ff @(posedge wclk) begin
        if (wen) mem[waddr] <= w_data;
    end

    always_ff @(posedge rclk) begin
        if (r_req) r_data <= mem[raddr];
    end
endmodule

// File: tb/tb_vid_rate_linebuf.sv
module tb_vid_rate_linebuf;
    localparam int LINE_PIX = 256;
    localparam int LINES    = 16;
    localparam int LOCK_PIX = 128;

    logic       wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
    logic       w_sof = 0, w_valid = 0, r_sof = 0, r_req = 0, r_line_done = 0;
    logic [7:0] w_data = 0, r_pix = 0, r_data;
    logic       w_lock, w_overflow, r_valid, r_underrun;
    logic [4:0] w_lead;

    int checks = 0, errors = 0;
    int gidx = 0, lock_cnt = 0, lock_at = -1;
    int rv = 0, rd_v = 0, ru = 0;

    always #2 wclk = ~wclk;
    always #3 rclk = ~rclk;

    vid_rate_linebuf dut (
        .wclk(wclk), .wrst_n(wrst_n), .w_sof(w_sof), .w_valid(w_valid), .w_data(w_data),
        .w_lock(w_lock), .w_overflow(w_overflow), .w_lead(w_lead),
        .rclk(rclk), .rrst_n(rrst_n), .r_sof(r_sof), .r_req(r_req), .r_pix(r_pix),
        .r_line_done(r_line_done), .r_valid(r_valid), .r_data(r_data), .r_underrun(r_underrun)
    );

    function automatic int pat(input int l, input int p);
        return (l * 37 + p * 3 + 1) & 8'hFF;
    endfunction

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    task automatic push(input int l, input int p);
        @(negedge wclk);
        w_valid = 1; w_data = 8'(pat(l, p));
        @(posedge wclk); #1;
        w_valid = 0;
        if (w_lock) begin lock_cnt++; lock_at = gidx; end
        gidx++;
    endtask

    task automatic push_line(input int l, input int from, input int upto);
        for (int p = from; p < upto; p++) push(l, p);
    endtask

    task automatic wsof();
        @(negedge wclk); w_sof = 1;
        @(posedge wclk); #1; w_sof = 0;
        gidx = 0; lock_cnt = 0; lock_at = -1;
    endtask

    task automatic rsof();
        @(negedge rclk); r_sof = 1;
        @(posedge rclk); #1; r_sof = 0;
    endtask

    task automatic rd(input int p);
        @(negedge rclk); r_req = 1; r_pix = 8'(p);
        @(posedge rclk); #1; r_req = 0;
        rv = int'(r_valid); rd_v = int'(r_data); ru = int'(r_underrun);
    endtask

    task automatic retire();
        @(negedge rclk); r_line_done = 1;
        @(posedge rclk); #1; r_line_done = 0;
    endtask

    task automatic settle();
        #100;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 lock", int'(w_lock), 0);
        chk("R1 overflow", int'(w_overflow), 0);
        chk("R1 lead", int'(w_lead), 0);
        chk("R1 r_valid", int'(r_valid), 0);
        chk("R1 underrun", int'(r_underrun), 0);
    endtask

    task automatic t_idle();
        push_line(0, 0, LINE_PIX);
        settle();
        chk("R2 lead idle", int'(w_lead), 0);
        chk("R2 no lock idle", lock_cnt, 0);
    endtask

    task automatic t_fill();
        wsof();
        push_line(0, 0, LINE_PIX);
        chk("R4 one lock", lock_cnt, 1);
        chk("R4 lock index", lock_at, LOCK_PIX - 1);
        settle();
        chk("R3/R5 lead after line 0", int'(w_lead), 1);
        for (int l = 1; l < LINES; l++) push_line(l, 0, LINE_PIX);
        settle();
        chk("R5 lead full", int'(w_lead), LINES);
        chk("R4 still one lock", lock_cnt, 1);
        rd(0);   chk("R6 valid p0", rv, 1);  chk("R6 data p0", rd_v, pat(0, 0));
        rd(100); chk("R6 data p100", rd_v, pat(0, 100));
        rd(255); chk("R6 data p255", rd_v, pat(0, 255));
        push(99, 0);
        chk("R9 overflow set", int'(w_overflow), 1);
        chk("R9 lead held", int'(w_lead), LINES);
        rd(0);   chk("R9 slot kept", rd_v, pat(0, 0));
        retire();
        settle();
        chk("R8 lead after retire", int'(w_lead), LINES - 1);
    endtask

    task automatic t_early();
        rsof();
        settle();
        wsof();
        chk("R3 overflow cleared", int'(w_overflow), 0);
        push_line(50, 0, LOCK_PIX);
        chk("R4 lock new frame", lock_cnt, 1);
        chk("R4 lock index new frame", lock_at, LOCK_PIX - 1);
        settle();
        rd(5);   chk("R10 valid p5", rv, 1); chk("R10 data p5", rd_v, pat(50, 5));
        rd(LOCK_PIX - 1); chk("R10 data last locked", rd_v, pat(50, LOCK_PIX - 1));
        rd(LOCK_PIX);
        chk("R7 r_valid low", rv, 0);
        chk("R7 underrun set", ru, 1);
        retire();
        push_line(50, LOCK_PIX, LINE_PIX);
        settle();
        chk("R8 early retire ignored", int'(w_lead), 1);
        rd(200); chk("R6 data p200", rd_v, pat(50, 200));
        chk("R7 underrun sticky", int'(r_underrun), 1);
        rsof();
        chk("R7 underrun cleared", int'(r_underrun), 0);
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20;
        wrst_n = 1; rrst_n = 1;
        t_reset();
        t_idle();
        t_fill();
        t_early();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule